// File: doc/BRIEF.md
# Precise Exception Controller for a Five-Stage Pipeline

This block keeps exceptions precise in an in-order pipeline with fetch, decode, execute and memory stages followed by writeback. Every instruction receives a tag when it is fetched. The tag holds the instruction's own PC, a fault flag and a 2-bit cause. The tag travels with the instruction from stage to stage. A stage that detects a problem only marks the tag of the instruction it holds, and the pipeline keeps flowing.

Nothing is done about a fault until the marked instruction reaches the boundary between the memory stage and writeback. In that cycle the block performs four actions:
- It withholds the instruction's commit, so no register write or store takes place.
- It kills every instruction in fetch through memory.
- It stores the faulting PC as the return point and stores the cause code.
- On the next cycle it starts fetching from a fixed handler address.

As a result, every instruction older than the faulting one has already committed, and none of the younger ones ever commits.

The surrounding datapath uses the outputs as follows. It fetches from `pc_o`. It writes back only the instruction that `commit_o` names. It clears its stage registers whenever `flush_o` is high.

Top module: `pex_ctrl`

## Requirements
- R1: While reset is held, `pc_o` equals RESET_PC (default 0x100), `commit_o`, `flush_o` and `exc_taken_o` are 0, and `epc_o` and `cause_o` are 0.
- R2: With no exception taken, `pc_o` increases by STEP (default 4) every cycle.
- R3: An instruction fetched at PC p in cycle t appears at the commit boundary in cycle t+3 with `commit_o`=1 and `commit_pc_o`=p, provided it is unmarked and has not been killed.
- R4: The cause code is set by the stage that raised the fault: 0 for fetch (`raise_if`), 1 for illegal instruction (`raise_id`), 2 for arithmetic (`raise_ex`) and 3 for data access (`raise_mem`). A marked instruction still reaches the commit boundary three cycles after fetch.
- R5: In the cycle a marked instruction is at the commit boundary, `exc_taken_o` and `flush_o` are 1, `commit_o` is 0, and `commit_pc_o` shows the faulting PC.
- R6: All instructions older than the faulting one commit. The younger instructions in flight never commit, and the commit boundary stays empty for the three cycles after the flush.
- R7: In the cycle after a flush, `pc_o` equals VEC_PC (default 0x80), and fetch then continues sequentially from that address.
- R8: From the cycle after a flush, `epc_o` holds the faulting PC and `cause_o` holds its code. Both keep those values afterwards.
- R9: When one instruction is marked by several stages, the code from the earliest stage is kept.
- R10: When a younger instruction is marked before an older one, only the older one is taken, and its cause is reported.
- R11: A raise input asserted while its stage holds no instruction has no effect on the commit stream or on the fetch PC.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| raise_if | input | 1 | The instruction in fetch has a fetch fault |
| raise_id | input | 1 | The instruction in decode is illegal |
| raise_ex | input | 1 | The instruction in execute has an arithmetic fault |
| raise_mem | input | 1 | The instruction in memory has a data access fault |
| pc_o | output | 32 | Address to fetch this cycle |
| flush_o | output | 1 | Kill every instruction in fetch through memory |
| commit_o | output | 1 | The instruction at the commit boundary may write back |
| commit_pc_o | output | 32 | PC of the instruction at the commit boundary |
| exc_taken_o | output | 1 | An exception is taken this cycle |
| epc_o | output | 32 | Saved return PC |
| cause_o | output | 2 | Saved cause code |

## Verification
The bench runs eight short programs with the following fault patterns:
- No fault at all, which shows plain sequential commit.
- A single fault in each of the four stages. Each of these must produce its own code and its own return PC, which separates the stages from one another.
- The decode and memory stages both marking the same instruction. This distinguishes keeping the first mark from overwriting it with the later one.
- A younger instruction marked in fetch and another in execute while an older one faults in memory. This shows whether ordering follows the program or the order in which faults were detected.
- Raises driven into empty slots after reset and after a flush, together with a fault on the very first instruction. This shows that bubbles carry no fault.

// File: rtl/pex_pkg.sv
package pex_pkg;

  parameter int unsigned PEX_AW = 32;

  typedef enum logic [1:0] {
    CZ_FETCH   = 2'd0,
    CZ_ILLEGAL = 2'd1,
    CZ_ARITH   = 2'd2,
    CZ_DATA    = 2'd3
  } pex_cause_e;

  // Per-instruction tag carried alongside the datapath
  typedef struct packed {
    logic              valid;
    logic              exc;
    pex_cause_e        cause;
    logic [PEX_AW-1:0] pc;
  } pex_tag_t;

  localparam pex_tag_t TAG_EMPTY = '0;

  // New tag for an instruction entering fetch
  function automatic pex_tag_t tag_fetch(input logic [PEX_AW-1:0] pc);
    pex_tag_t t;
    t.valid = 1'b1;
    t.exc   = 1'b0;
    t.cause = CZ_FETCH;
    t.pc    = pc;
    return t;
  endfunction

  // Mark a tag with a stage fault; a mark already present is kept
  function automatic pex_tag_t tag_mark(input pex_tag_t t, input logic raise,
                                        input pex_cause_e code);
    pex_tag_t r;
    r = t;
    if (t.valid && raise && !t.exc) begin
      r.exc   = 1'b1;
      r.cause = code;
    end
    return r;
  endfunction

  // Fetch address for the following cycle
  function automatic logic [PEX_AW-1:0] pc_advance(input logic [PEX_AW-1:0] pc,
                                                   input logic take,
                                                   input logic [PEX_AW-1:0] vec,
                                                   input logic [PEX_AW-1:0] step);
    return take ? vec : pc + step;
  endfunction

endpackage

// File: rtl/pex_fetch.sv
module pex_fetch
  import pex_pkg::*;
#(
  parameter logic [PEX_AW-1:0] RESET_PC = 32'h0000_0100,
  parameter logic [PEX_AW-1:0] VEC_PC   = 32'h0000_0080,
  parameter int unsigned       STEP     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  output logic [PEX_AW-1:0] pc_q
);

  localparam logic [PEX_AW-1:0] STEP_W = PEX_AW'(STEP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_q <= RESET_PC;
    else        pc_q <= pc_advance(pc_q, take, VEC_PC, STEP_W);
  end

  // R7
  vec_redirect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (pc_q == VEC_PC));

  // R2
  seq_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> (pc_q == $past(pc_q) + STEP_W));

endmodule

// File: rtl/pex_stage.sv
module pex_stage
  import pex_pkg::*;
#(
  parameter pex_cause_e CODE = CZ_ILLEGAL
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     kill,
  input  logic     raise,
  input  pex_tag_t in_tag,
  output pex_tag_t q_tag,
  output pex_tag_t out_tag
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q_tag <= TAG_EMPTY;
    else if (kill) q_tag <= TAG_EMPTY;
    else           q_tag <= in_tag;
  end

  assign out_tag = tag_mark(q_tag, raise, CODE);

  // R9
  first_mark_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!kill && in_tag.valid && in_tag.exc) |=>
      (out_tag.exc && out_tag.cause == $past(in_tag.cause)));

  // R6
  flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    kill |=> !q_tag.valid);

endmodule

// File: rtl/pex_commit.sv
module pex_commit
  import pex_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  pex_tag_t          fin_tag,
  output logic              take,
  output logic              commit,
  output logic [PEX_AW-1:0] commit_pc,
  output logic [PEX_AW-1:0] epc_q,
  output pex_cause_e        cause_q
);

  assign take      = fin_tag.valid &&  fin_tag.exc;
  assign commit    = fin_tag.valid && !fin_tag.exc;
  assign commit_pc = fin_tag.pc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      epc_q   <= '0;
      cause_q <= CZ_FETCH;
    end else if (take) begin
      epc_q   <= fin_tag.pc;
      cause_q <= fin_tag.cause;
    end
  end

  // R8
  epc_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (epc_q == $past(commit_pc)));

  // R5
  take_or_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({take, commit}));

  // R6
  bubble_after_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !commit);

endmodule

// File: rtl/pex_ctrl.sv
module pex_ctrl
  import pex_pkg::*;
#(
  parameter logic [31:0] RESET_PC = 32'h0000_0100,
  parameter logic [31:0] VEC_PC   = 32'h0000_0080,
  parameter int unsigned STEP     = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        raise_if,
  input  logic        raise_id,
  input  logic        raise_ex,
  input  logic        raise_mem,
  output logic [31:0] pc_o,
  output logic        flush_o,
  output logic        commit_o,
  output logic [31:0] commit_pc_o,
  output logic        exc_taken_o,
  output logic [31:0] epc_o,
  output logic [1:0]  cause_o
);

  localparam int unsigned NSTG = 3;  // tag registers: decode, execute, memory

  logic                take;
  logic                commit;
  logic [PEX_AW-1:0]   pc_q;
  logic [PEX_AW-1:0]   cpc;
  logic [PEX_AW-1:0]   epc_q;
  pex_cause_e          cause_q;
  logic [NSTG:0]       raise_vec;
  pex_tag_t            marked [0:NSTG];
  pex_tag_t            held   [1:NSTG];

  assign raise_vec = {raise_mem, raise_ex, raise_id, raise_if};

  pex_fetch #(.RESET_PC(RESET_PC), .VEC_PC(VEC_PC), .STEP(STEP)) u_fetch (
    .clk  (clk),
    .rst_n(rst_n),
    .take (take),
    .pc_q (pc_q)
  );

  assign marked[0] = tag_mark(tag_fetch(pc_q), raise_vec[0], CZ_FETCH);

  genvar k;
  generate
    for (k = 1; k <= NSTG; k++) begin : g_stage
      pex_stage #(.CODE(pex_cause_e'(k))) u_stage (
        .clk    (clk),
        .rst_n  (rst_n),
        .kill   (take),
        .raise  (raise_vec[k]),
        .in_tag (marked[k-1]),
        .q_tag  (held[k]),
        .out_tag(marked[k])
      );
    end
  endgenerate

  pex_commit u_commit (
    .clk      (clk),
    .rst_n    (rst_n),
    .fin_tag  (marked[NSTG]),
    .take     (take),
    .commit   (commit),
    .commit_pc(cpc),
    .epc_q    (epc_q),
    .cause_q  (cause_q)
  );

  assign pc_o        = pc_q;
  assign flush_o     = take;
  assign exc_taken_o = take;
  assign commit_o    = commit;
  assign commit_pc_o = cpc;
  assign epc_o       = epc_q;
  assign cause_o     = cause_q;

  // R10
  oldest_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && held[NSTG-1].valid) |=> !held[NSTG].valid);

  // R3
  commit_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && held[NSTG].valid && $past(commit)) |->
      (cpc == $past(cpc) + PEX_AW'(STEP)));

endmodule

// File: tb/sim_pex_ctrl.sv
`timescale 1ns/1ps
module sim_pex_ctrl;

  localparam logic [31:0] RST_PC = 32'h100;
  localparam logic [31:0] VEC    = 32'h80;
  localparam logic [31:0] NONE   = 32'hFFFF_FFFF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        raise_if = 1'b0, raise_id = 1'b0, raise_ex = 1'b0, raise_mem = 1'b0;
  logic [31:0] pc_o, commit_pc_o, epc_o;
  logic        flush_o, commit_o, exc_taken_o;
  logic [1:0]  cause_o;

  always #10 clk = ~clk;  // 50 MHz

  pex_ctrl u0 (
    .clk(clk), .rst_n(rst_n),
    .raise_if(raise_if), .raise_id(raise_id), .raise_ex(raise_ex), .raise_mem(raise_mem),
    .pc_o(pc_o), .flush_o(flush_o), .commit_o(commit_o), .commit_pc_o(commit_pc_o),
    .exc_taken_o(exc_taken_o), .epc_o(epc_o), .cause_o(cause_o)
  );

  typedef struct {
    bit          is_exc;
    logic [31:0] pc;
    logic [1:0]  cause;
  } item_t;

  item_t q[$];
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  int cyc = 0;

  // fault plan
  logic [31:0] f_if, f_id, f_ex, f_mem;
  bit          junk;
  string       ctag;

  // bench view of the pipeline
  logic        bv_id, bv_ex, bv_mem;
  logic [31:0] bp_id, bp_ex, bp_mem, b_pc;
  bit          after_take, epc_pend;
  logic [31:0] epc_exp;
  logic [1:0]  cause_exp;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  // Driver side: expected commit stream from the fault plan
  task automatic plan_stream();
    logic [31:0] pc;
    bit taken;
    item_t it;
    pc = RST_PC;
    taken = 1'b0;
    q.delete();
    for (int i = 0; i < 40; i++) begin
      it.is_exc = 1'b0;
      it.pc = pc;
      it.cause = 2'd0;
      if (!taken && (pc == f_if || pc == f_id || pc == f_ex || pc == f_mem)) begin
        it.is_exc = 1'b1;
        // earliest stage first (R9)
        if (pc == f_if)      it.cause = 2'd0;
        else if (pc == f_id) it.cause = 2'd1;
        else if (pc == f_ex) it.cause = 2'd2;
        else                 it.cause = 2'd3;
        taken = 1'b1;
        q.push_back(it);
        pc = VEC;
      end else begin
        q.push_back(it);
        pc = pc + 32'd4;
      end
    end
  endtask

  // Monitor side: one cycle, run at a falling edge
  task automatic step();
    item_t it;
    bit take;
    take = 1'b0;
    chk(pc_o === b_pc, after_take ? "R7" : "R2", pc_o, b_pc);
    if (epc_pend) begin
      chk(epc_o === epc_exp, "R8", epc_o, epc_exp);
      chk(cause_o === cause_exp, ctag, {30'd0, cause_o}, {30'd0, cause_exp});
      epc_pend = 1'b0;
    end
    raise_if  = (b_pc == f_if);
    raise_id  = bv_id  ? (bp_id  == f_id)  : junk;
    raise_ex  = bv_ex  ? (bp_ex  == f_ex)  : junk;
    raise_mem = bv_mem ? (bp_mem == f_mem) : junk;
    #1;
    if (bv_mem) begin
      if (q.size() == 0) begin
        chk(1'b0, "R3", commit_pc_o, bp_mem);
      end else begin
        it = q.pop_front();
        if (it.is_exc) begin
          chk(exc_taken_o === 1'b1 && flush_o === 1'b1 && commit_o === 1'b0, "R5",
              {29'd0, exc_taken_o, flush_o, commit_o}, 32'd6);
          chk(commit_pc_o === it.pc, "R5", commit_pc_o, it.pc);
          epc_pend  = 1'b1;
          epc_exp   = it.pc;
          cause_exp = it.cause;
          take      = 1'b1;
        end else begin
          chk(commit_o === 1'b1 && exc_taken_o === 1'b0 && flush_o === 1'b0, "R3",
              {29'd0, exc_taken_o, flush_o, commit_o}, 32'd1);
          chk(commit_pc_o === it.pc, "R3", commit_pc_o, it.pc);
        end
      end
    end else begin
      chk(commit_o === 1'b0 && exc_taken_o === 1'b0,
          junk ? "R11" : (after_take ? "R6" : "R1"),
          {30'd0, commit_o, exc_taken_o}, 32'd0);
    end
    if (take) begin
      bv_id = 1'b0; bv_ex = 1'b0; bv_mem = 1'b0;
      b_pc = VEC;
      after_take = 1'b1;
    end else begin
      bv_mem = bv_ex; bp_mem = bp_ex;
      bv_ex  = bv_id; bp_ex  = bp_id;
      bv_id  = 1'b1;  bp_id  = b_pc;
      b_pc   = b_pc + 32'd4;
    end
  endtask

  task automatic run_case(input logic [31:0] a, b, c, d, input bit jk, input string tag);
    rst_n = 1'b0;
    raise_if = 0; raise_id = 0; raise_ex = 0; raise_mem = 0;
    f_if = a; f_id = b; f_ex = c; f_mem = d; junk = jk; ctag = tag;
    plan_stream();
    bv_id = 0; bv_ex = 0; bv_mem = 0;
    bp_id = 0; bp_ex = 0; bp_mem = 0;
    b_pc = RST_PC; after_take = 0; epc_pend = 0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (22) begin
      step();
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(pc_o === RST_PC, "R1", pc_o, RST_PC);
    chk(commit_o === 1'b0 && flush_o === 1'b0 && exc_taken_o === 1'b0, "R1",
        {29'd0, commit_o, flush_o, exc_taken_o}, 32'd0);
    chk(epc_o === 32'd0 && cause_o === 2'd0, "R1", epc_o, 32'd0);

    run_case(NONE,   NONE,   NONE,   NONE,   1'b0, "R4");   // plain stream
    run_case(32'h10C, NONE,  NONE,   NONE,   1'b0, "R4");   // fetch fault
    run_case(NONE,   32'h110, NONE,  NONE,   1'b0, "R4");   // illegal
    run_case(NONE,   NONE,   32'h108, NONE,  1'b0, "R4");   // arithmetic
    run_case(NONE,   NONE,   NONE,   32'h104, 1'b0, "R4");  // data fault
    run_case(NONE,   32'h10C, NONE,  32'h10C, 1'b0, "R9");  // two marks, one instr
    run_case(32'h118, NONE,  32'h114, 32'h110, 1'b0, "R10"); // younger marked first
    run_case(NONE,   NONE,   NONE,   32'h100, 1'b1, "R4");  // R11 junk on bubbles
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 4000 && !done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=%0d expected<=4000 cycles", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule